// File: doc/BRIEF.md
# PLL Lock Status Detector

This block decides whether a clock-recovery loop is locked by watching the recovered clock. On every tick of an independent line-sample clock the front end hands over one sampled bit of the recovered clock. A locked loop gives samples that stay low. A loop that is drifting gives high samples. The block drives one status flag, `lock_o`. The flag is low when the loop is locked and high when it is unlocked.

The two decisions are deliberately asymmetric. A single unbroken run of low samples is enough to declare lock. Loss of lock needs repeated evidence: fixed-length frames of samples are graded, and only a series of consecutive bad frames releases the lock. Between these two events the flag holds its value. The flag is registered on the sample clock. The reset input is asynchronous and active low, and its release passes through a two-stage synchroniser.

Top module: `lock_status_det`

## Requirements
- R1: `lock_o` goes low on the clock edge that captures the 32nd low sample of an unbroken run of low samples. A run of 31 low samples leaves it unchanged.
- R2: Any high sample restarts the low run, so 32 further low samples are needed after it.
- R3: Frames are 256 sample edges long and do not overlap. They run freely, and the first frame starts at the third rising clock edge after `rst_n_i` rises. Only samples inside a frame's own window count toward that frame.
- R4: A frame is bad when it contains more than 5 high samples. A frame with exactly 5 high samples is good.
- R5: `lock_o` goes high on the edge that captures the last sample of the fifth bad frame in a row.
- R6: A good frame restarts the count of consecutive bad frames.
- R7: When neither the lock condition nor the unlock condition is met on an edge, `lock_o` keeps its value.
- R8: While `rst_n_i` is low, `lock_o` is high, and it goes high immediately when reset is asserted. After release, the first two edges are spent in the synchroniser: samples are ignored and `lock_o` stays high.
- R9: The count of high samples saturates, so a frame of 256 high samples is still graded bad.
- R10: If the lock and unlock conditions complete on the same edge, the lock condition wins and `lock_o` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp_i | input | 1 | Line-sample clock; all state is updated on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rclk_smp_i | input | 1 | Recovered-clock bit as sampled on the current sample edge |
| lock_o | output | 1 | Lock status flag: 0 locked, 1 unlocked |

## Verification
The assertions assume that the sampled bit is synchronous to the sample clock and is settled at each rising edge. They also assume that reset is held for at least one edge before it is released. The bench meets both conditions by changing the sampled bit and the reset only on falling edges, and by holding reset across several cycles. The frame patterns are generated from the bench's own frame position, counted from the release of reset. This lets the stimulus place high samples exactly at frame boundaries: inside one frame, or straddling two frames. It also lets the stimulus line up the lock and unlock conditions on one edge.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  localparam int unsigned DEF_RUN_LEN    = 32;
  localparam int unsigned DEF_FRAME_LEN  = 256;
  localparam int unsigned DEF_HIGH_LIMIT = 5;
  localparam int unsigned DEF_BAD_FRAMES = 5;

  typedef enum logic {
    ST_LOCKED   = 1'b0,
    ST_UNLOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/ld_low_run.sv
module ld_low_run #(
  parameter int unsigned RUN_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  output logic hit_o
);
  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    hit_o = 1'b0;
    if (smp_i) begin
      run_d = '0;
    end else if (run_q >= RUN_TOP) begin
      hit_o = 1'b1;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R2: a high sample means no lock decision on the following edge
  p_high_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (RUN_LEN > 1 && smp_i) |=> !hit_o);
endmodule

// File: rtl/ld_frame.sv
module ld_frame #(
  parameter int unsigned FRAME_LEN  = 256,
  parameter int unsigned HIGH_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  output logic end_o,
  output logic bad_o
);
  localparam int unsigned POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam int unsigned HI_W  = $clog2(HIGH_LIMIT + 2);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);
  localparam logic [HI_W-1:0]  HI_SAT   = HI_W'(HIGH_LIMIT + 1);
  localparam logic [HI_W-1:0]  HI_LIM   = HI_W'(HIGH_LIMIT);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [HI_W-1:0]  hi_q, hi_d, hi_tot;

  always_comb begin
    hi_tot = hi_q;
    if (smp_i && (hi_q < HI_SAT)) hi_tot = hi_q + 1'b1;
    end_o = (pos_q == POS_LAST);
    bad_o = end_o && (hi_tot > HI_LIM);
    if (end_o) begin
      pos_d = '0;
      hi_d  = '0;
    end else begin
      pos_d = pos_q + 1'b1;
      hi_d  = hi_tot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      hi_q  <= '0;
    end else begin
      pos_q <= pos_d;
      hi_q  <= hi_d;
    end
  end

  // R3: frames do not overlap, so no two frame ends are adjacent
  p_frame_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (FRAME_LEN > 1 && end_o) |=> !end_o);
  // R9: the high count never grows past its saturation value
  p_hi_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q <= HI_SAT);
endmodule

// File: rtl/ld_bad_run.sv
module ld_bad_run #(
  parameter int unsigned BAD_FRAMES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic end_i,
  input  logic bad_i,
  output logic unlock_o
);
  localparam int unsigned BAD_W = $clog2(BAD_FRAMES + 1);
  localparam logic [BAD_W-1:0] BAD_TOP = BAD_W'(BAD_FRAMES - 1);

  logic [BAD_W-1:0] bad_q, bad_d;

  always_comb begin
    bad_d    = bad_q;
    unlock_o = end_i && bad_i && (bad_q >= BAD_TOP);
    if (end_i) begin
      if (!bad_i)               bad_d = '0;
      else if (bad_q < BAD_TOP) bad_d = bad_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= '0;
    else        bad_q <= bad_d;
  end

  // R6: a good frame leaves no bad-frame history
  p_good_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !bad_i) |=> (bad_q == '0));
endmodule

// File: rtl/lock_status_det.sv
module lock_status_det
  import lock_det_pkg::*;
#(
  parameter int unsigned RUN_LEN    = DEF_RUN_LEN,
  parameter int unsigned FRAME_LEN  = DEF_FRAME_LEN,
  parameter int unsigned HIGH_LIMIT = DEF_HIGH_LIMIT,
  parameter int unsigned BAD_FRAMES = DEF_BAD_FRAMES
) (
  input  logic clk_smp_i,
  input  logic rst_n_i,
  input  logic rclk_smp_i,
  output logic lock_o
);
  logic [1:0]  rst_sync_q;
  logic        rst_s;
  logic        lock_hit, unlock_hit, frame_end, frame_bad;
  lock_state_e st_q, st_d;

  always_ff @(posedge clk_smp_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  ld_low_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk_smp_i), .rst_n(rst_s), .smp_i(rclk_smp_i), .hit_o(lock_hit)
  );

  ld_frame #(.FRAME_LEN(FRAME_LEN), .HIGH_LIMIT(HIGH_LIMIT)) u_frame (
    .clk(clk_smp_i), .rst_n(rst_s), .smp_i(rclk_smp_i),
    .end_o(frame_end), .bad_o(frame_bad)
  );

  ld_bad_run #(.BAD_FRAMES(BAD_FRAMES)) u_bad (
    .clk(clk_smp_i), .rst_n(rst_s), .end_i(frame_end), .bad_i(frame_bad),
    .unlock_o(unlock_hit)
  );

  always_comb begin
    st_d = st_q;
    if (lock_hit)        st_d = ST_LOCKED;
    else if (unlock_hit) st_d = ST_UNLOCKED;
  end

  always_ff @(posedge clk_smp_i or negedge rst_s) begin
    if (!rst_s) st_q <= ST_UNLOCKED;
    else        st_q <= st_d;
  end

  assign lock_o = (st_q == ST_UNLOCKED);

  // R1: lock is only taken after a low run completes on a low sample
  p_lock_needs_low_r1: assert property (@(posedge clk_smp_i) disable iff (!rst_s)
    $fell(lock_o) |-> ($past(lock_hit) && !$past(rclk_smp_i)));
  // R5: unlock only happens on a frame's closing edge
  p_unlock_at_end_r5: assert property (@(posedge clk_smp_i) disable iff (!rst_s)
    $rose(lock_o) |-> $past(frame_end));
  // R7: without either decision the flag holds
  p_hold_r7: assert property (@(posedge clk_smp_i) disable iff (!rst_s)
    (!lock_hit && !unlock_hit) |=> $stable(lock_o));
  // R10: a completed low run overrides a simultaneous unlock
  p_lock_wins_r10: assert property (@(posedge clk_smp_i) disable iff (!rst_s)
    lock_hit |=> !lock_o);
endmodule

// File: tb/sim_lock_status_det.sv
module sim_lock_status_det;
  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp = 1'b0;
  logic lock;

  item_t sb_q[$];
  int n_chk = 0;
  int n_err = 0;

  int low_run, pos, hi, bad_run;
  bit lock_exp;

  always #5 clk = ~clk;

  lock_status_det u0 (
    .clk_smp_i(clk), .rst_n_i(rst_n), .rclk_smp_i(smp), .lock_o(lock)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: lock_o actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model of the requirements
  task automatic model_reset();
    low_run = 0; pos = 0; hi = 0; bad_run = 0; lock_exp = 1'b1;
  endtask

  task automatic model_step(input bit s);
    bit lk, ul, fin, bad;
    int tot;
    lk = !s && (low_run >= 31);
    low_run = s ? 0 : low_run + 1;
    tot = hi + (s ? 1 : 0);
    fin = (pos == 255);
    bad = tot > 5;
    ul = fin && bad && (bad_run >= 4);
    if (fin) begin
      bad_run = bad ? bad_run + 1 : 0;
      hi = 0;
      pos = 0;
    end else begin
      hi = tot;
      pos++;
    end
    if (lk)      lock_exp = 1'b0;
    else if (ul) lock_exp = 1'b1;
  endtask

  // driver: one sample per cycle, expected result into the scoreboard
  task automatic drive(input bit s, input string tag);
    item_t it;
    @(negedge clk);
    smp <= s;
    model_step(s);
    it.exp = lock_exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive_n(input int n, input bit s, input string tag);
    for (int i = 0; i < n; i++) drive(s, tag);
  endtask

  task automatic align(input string tag);
    while (pos != 0) drive(1'b0, tag);
  endtask

  function automatic bit pat(input int mode, input int p);
    case (mode)
      0: return (p % 50 == 0) && (p < 250);      // exactly 5 highs
      1: return (p % 50 == 0);                   // 6 highs
      2: return 1'b1;                            // all high
      3: return (p < 6);                         // 6 highs then long low run
      4: return (p < 3) || (p == 253) || (p == 254);
      default: return (p % 20 == 0);             // sparse highs
    endcase
  endfunction

  task automatic frames(input int n, input int mode, input string tag);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < 256; i++) drive(pat(mode, pos), tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n <= 1'b0;
    #1 check(lock, 1'b1, "R8 assert");
    model_reset();
    repeat (3) @(negedge clk);
    check(lock, 1'b1, "R8 held");
  endtask

  task automatic release_rst();
    item_t it;
    @(negedge clk);
    rst_n <= 1'b1;
    smp <= 1'b0;
    it.exp = 1'b1; it.tag = "R8 sync";
    sb_q.push_back(it);
    @(negedge clk);
    sb_q.push_back(it);
  endtask

  // monitor: compares away from the active edge
  always @(posedge clk) begin
    item_t it;
    #2;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(lock, it.exp, it.tag);
    end
  end

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    release_rst();
    drive_n(20, 1'b0, "R2");
    drive(1'b1, "R2");
    drive_n(31, 1'b0, "R2");
    drive(1'b0, "R1");
    drive_n(10, 1'b1, "R7");
    drive_n(31, 1'b0, "R1 boundary");
    drive(1'b1, "R1 boundary");
    drive_n(32, 1'b0, "R1");
    align("R7");
    frames(6, 0, "R4");
    frames(4, 1, "R6");
    frames(1, 0, "R6");
    frames(4, 1, "R6");
    frames(1, 1, "R5");
    frames(2, 5, "R7");
    drive_n(32, 1'b0, "R1");
    align("R7");
    frames(5, 2, "R9");
    drive_n(40, 1'b0, "R1");
    align("R7");
    frames(4, 1, "R10");
    frames(1, 3, "R10");
    frames(5, 4, "R3");
    do_reset();
    release_rst();
    drive_n(31, 1'b0, "R8");
    drive(1'b0, "R1");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule